// File: doc/BRIEF.md
# IR run-length transmitter with carrier modulator

This block plays an infrared waveform described as a stream of run-length bytes. Each byte says whether the next stretch is a mark (emitter lit) or a space (emitter dark), and how many sample periods it lasts. The host owns two sample slots and fills them in turn. The block consumes slot 0 first, then slot 1, then slot 0 again, and so on. Each time a slot is consumed, a sticky request flag is raised so the host can write the following byte into the slot that was just freed.

During a mark the output can be gated by a carrier. The carrier period and the high width are counted in carrier units of `UNIT_CLKS` clocks, and a polarity bit chooses whether the high part comes first in each period. When the carrier is disabled, marks are sent as a steady high level. A two-bit mask chooses which of the two emitter outputs follow the waveform. If the next slot is still empty when a sample ends, the outputs drop low and the transmission stops.

The host reaches the block through a single-cycle write port with a 3-bit address. Writing the start address begins playback, provided slot 0 holds a sample.

Top module: `irtx_runlen`

## Requirements
- R1: After reset the block is idle with both emitters low and the request flag clear. The carrier settings are period 32 units, high width 16 units, polarity bit set and carrier enabled, and the emitter mask is 2'b11. A transmission started without any configuration write uses these values.
- R2: A sample byte written to address 0 or 1 encodes a mark when bit 7 is 1 and a space when bit 7 is 0. Bits 6:0 give the length in sample periods of `SAMPLE_CLKS` clocks each, and a length of 0 counts as 1. The first sample appears on the emitters one clock after the edge that registers the start write (address 7, data ignored). Each later sample follows the previous one with no gap.
- R3: Slots are consumed alternately, beginning with slot 0 (address 0) and then slot 1 (address 1). A start write while slot 0 is empty is ignored: the block stays idle and the flag stays clear.
- R4: The request flag (irq_o, address 6 bit 0) is set on every edge that consumes a slot, including the first. It stays set until a write to address 6 with bit 0 equal to 0. Writing 1 there has no effect. A set and a clear on the same edge leave the flag set.
- R5: If the other slot is empty when a sample ends, busy_o and the emitters go low on the next cycle. A later start begins again from slot 0.
- R6: Address 2 holds the carrier period in bits 6:0, in units of `UNIT_CLKS` clocks, with 0 treated as 1. Bit 7 is the polarity. The carrier phase restarts at the beginning of every sample. With polarity 1 a mark is high for the first W units of each period and low for the rest; with polarity 0 the levels are swapped.
- R7: Address 3 bits 6:0 hold the high width W, and 0 is treated as 1. A width equal to or larger than the period gives a constant level for the whole mark.
- R8: Address 4 bit 0 enables the carrier. When this bit is 0, marks are driven steady high.
- R9: Address 5 bits 1:0 form the emitter mask. Emitter i follows the waveform only while bit i is 1 and is held low otherwise.
- R10: Spaces and idle periods drive every emitter low, whatever the carrier settings.
- R11: The largest length, 127, gives a sample of exactly 127 × `SAMPLE_CLKS` clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 3 | Write address (0,1 slots; 2 carrier period; 3 high width; 4 control; 5 mask; 6 request flag; 7 start) |
| wr_data | input | 8 | Write data |
| emit_o | output | N_EMIT | Registered emitter drive, one bit per emitter |
| irq_o | output | 1 | Sticky request flag: a slot was consumed |
| busy_o | output | 1 | Transmission in progress |

## Verification
The assertions assume that the host never writes a slot on the same edge that the sequencer consumes it. They also assume that the carrier and mask settings do not change in the middle of a checked mark. The bench keeps to both: it changes configuration only while the block is idle, and it refills a slot exactly one cycle after seeing the request flag, which is at least one full sample before that slot is read again. Expected emitter levels come from arithmetic on the sample list and the carrier settings, cycle by cycle, over a sweep of period, width and polarity values, all masks, zero and maximum lengths, and streams that end in an underrun.

// File: rtl/irtx_pkg.sv
package irtx_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 7;   // duration field, bits 6:0
  localparam int PER_W  = 7;   // carrier period / width fields

  localparam logic [ADDR_W-1:0] ADR_SLOT0 = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_SLOT1 = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_CPER  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_CHIGH = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_CTRL  = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_MASK  = 3'd5;
  localparam logic [ADDR_W-1:0] ADR_REQ   = 3'd6;
  localparam logic [ADDR_W-1:0] ADR_GO    = 3'd7;

  localparam logic [PER_W-1:0] DEF_PERIOD = 7'd32;
  localparam logic [PER_W-1:0] DEF_HIGH   = 7'd16;

  typedef struct packed {
    logic             mark;
    logic [CNT_W-1:0] cnt;
  } sample_t;

  typedef struct packed {
    logic             pol;
    logic [PER_W-1:0] period;
    logic [PER_W-1:0] high;
    logic             cen;
  } carrier_cfg_t;
endpackage

// File: rtl/irtx_regs.sv
module irtx_regs
  import irtx_pkg::*;
#(
  parameter int N_EMIT = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                consume,
  input  logic                consume_sel,
  input  logic                req_set,
  output sample_t [1:0]       slot_q,
  output logic [1:0]          slot_vld,
  output carrier_cfg_t        ccfg,
  output logic [N_EMIT-1:0]   mask_q,
  output logic                req_q,
  output logic                go
);
  // Two sample slots, written by address, released when consumed (R3)
  for (genvar s = 0; s < 2; s++) begin : g_slot
    sample_t data_r;
    logic    vld_r;
    logic    hit;
    assign hit = wr_en && (wr_addr == ((s == 0) ? ADR_SLOT0 : ADR_SLOT1));
    always_ff @(posedge clk) begin
      if (rst) begin
        data_r <= '0;
        vld_r  <= 1'b0;
      end else if (hit) begin
        data_r <= sample_t'(wr_data);
        vld_r  <= 1'b1;
      end else if (consume && (consume_sel == 1'(s))) begin
        vld_r  <= 1'b0;
      end
    end
    assign slot_q[s]   = data_r;
    assign slot_vld[s] = vld_r;
  end

  // Carrier, control and mask settings with reset defaults (R1)
  always_ff @(posedge clk) begin
    if (rst) begin
      ccfg.pol    <= 1'b1;
      ccfg.period <= DEF_PERIOD;
      ccfg.high   <= DEF_HIGH;
      ccfg.cen    <= 1'b1;
      mask_q      <= '1;
    end else if (wr_en) begin
      case (wr_addr)
        ADR_CPER: begin
          ccfg.pol    <= wr_data[DATA_W-1];
          ccfg.period <= wr_data[PER_W-1:0];
        end
        ADR_CHIGH: ccfg.high <= wr_data[PER_W-1:0];
        ADR_CTRL:  ccfg.cen  <= wr_data[0];
        ADR_MASK:  mask_q    <= wr_data[N_EMIT-1:0];
        default: ;
      endcase
    end
  end

  // Sticky request flag: set wins over clear (R4)
  always_ff @(posedge clk) begin
    if (rst)
      req_q <= 1'b0;
    else if (req_set)
      req_q <= 1'b1;
    else if (wr_en && (wr_addr == ADR_REQ) && !wr_data[0])
      req_q <= 1'b0;
  end

  assign go = wr_en && (wr_addr == ADR_GO);
endmodule

// File: rtl/irtx_seq.sv
module irtx_seq
  import irtx_pkg::*;
#(
  parameter int SAMPLE_CLKS = 10000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  sample_t [1:0] slot_q,
  input  logic [1:0]    slot_vld,
  output logic          consume,
  output logic          consume_sel,
  output logic          restart,
  output logic          busy_q,
  output logic          mark_q
);
  localparam int MAX_LEN = ((1 << CNT_W) - 1) * SAMPLE_CLKS;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);

  logic             rd_sel;
  logic [LEN_W-1:0] remain;
  logic             sel;
  logic             at_end;
  logic             load;
  sample_t          cur;
  logic [CNT_W-1:0] cnt_eff;
  logic [LEN_W-1:0] len;

  always_comb begin
    sel     = busy_q ? rd_sel : 1'b0;           // a fresh start always reads slot 0 (R3, R5)
    at_end  = busy_q && (remain == LEN_W'(1));
    load    = (!busy_q && go && slot_vld[0]) ||
              (at_end && slot_vld[rd_sel]);
    cur     = slot_q[sel];
    cnt_eff = (cur.cnt == '0) ? CNT_W'(1) : cur.cnt;  // zero length acts as one (R2)
    len     = LEN_W'(cnt_eff) * LEN_W'(SAMPLE_CLKS);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      mark_q <= 1'b0;
      rd_sel <= 1'b0;
      remain <= '0;
    end else if (load) begin
      busy_q <= 1'b1;
      mark_q <= cur.mark;
      rd_sel <= ~sel;
      remain <= len;
    end else if (at_end) begin
      busy_q <= 1'b0;                           // underrun: stop (R5)
      mark_q <= 1'b0;
      rd_sel <= 1'b0;
      remain <= '0;
    end else if (busy_q) begin
      remain <= remain - LEN_W'(1);
    end
  end

  assign consume     = load;
  assign consume_sel = sel;
  assign restart     = load;
endmodule

// File: rtl/irtx_carrier.sv
module irtx_carrier
  import irtx_pkg::*;
#(
  parameter int UNIT_CLKS = 100
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  carrier_cfg_t ccfg,
  output logic         wave
);
  logic [PER_W-1:0] phase;
  logic [PER_W-1:0] eff_p;
  logic [PER_W-1:0] eff_h;
  logic             unit_tick;

  assign eff_p = (ccfg.period == '0) ? PER_W'(1) : ccfg.period;  // R6
  assign eff_h = (ccfg.high == '0) ? PER_W'(1) : ccfg.high;      // R7

  if (UNIT_CLKS > 1) begin : g_pre
    localparam int PRE_W = $clog2(UNIT_CLKS);
    logic [PRE_W-1:0] pre;
    assign unit_tick = (pre == PRE_W'(UNIT_CLKS - 1));
    always_ff @(posedge clk) begin
      if (rst || restart || unit_tick)
        pre <= '0;
      else
        pre <= pre + PRE_W'(1);
    end
  end else begin : g_nopre
    assign unit_tick = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || restart)
      phase <= '0;
    else if (unit_tick)
      phase <= (phase >= eff_p - PER_W'(1)) ? '0 : phase + PER_W'(1);
  end

  // polarity picks which level the first W units carry (R6)
  assign wave = (phase < eff_h) ? ccfg.pol : ~ccfg.pol;
endmodule

// File: rtl/irtx_runlen.sv
module irtx_runlen
  import irtx_pkg::*;
#(
  parameter int SAMPLE_CLKS = 10000,
  parameter int UNIT_CLKS   = 100,
  parameter int N_EMIT      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [7:0]        wr_data,
  output logic [N_EMIT-1:0] emit_o,
  output logic              irq_o,
  output logic              busy_o
);
  sample_t [1:0]     slot_q;
  logic [1:0]        slot_vld;
  carrier_cfg_t      ccfg;
  logic [N_EMIT-1:0] mask_q;
  logic              req_q;
  logic              go;
  logic              consume;
  logic              consume_sel;
  logic              restart;
  logic              busy_q;
  logic              mark_q;
  logic              wave;
  logic              carrier_on;
  logic              level;

  irtx_regs #(.N_EMIT(N_EMIT)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .consume(consume), .consume_sel(consume_sel), .req_set(consume),
    .slot_q(slot_q), .slot_vld(slot_vld), .ccfg(ccfg), .mask_q(mask_q),
    .req_q(req_q), .go(go)
  );

  irtx_seq #(.SAMPLE_CLKS(SAMPLE_CLKS)) u_seq (
    .clk(clk), .rst(rst), .go(go), .slot_q(slot_q), .slot_vld(slot_vld),
    .consume(consume), .consume_sel(consume_sel), .restart(restart),
    .busy_q(busy_q), .mark_q(mark_q)
  );

  irtx_carrier #(.UNIT_CLKS(UNIT_CLKS)) u_car (
    .clk(clk), .rst(rst), .restart(restart), .ccfg(ccfg), .wave(wave)
  );

  assign carrier_on = ccfg.cen;
  // marks follow the carrier or stay high; spaces and idle stay low (R8, R10)
  assign level = busy_q && mark_q && (carrier_on ? wave : 1'b1);

  for (genvar i = 0; i < N_EMIT; i++) begin : g_emit
    logic q;
    always_ff @(posedge clk) begin
      if (rst) q <= 1'b0;
      else     q <= level & mask_q[i];   // R9
    end
    assign emit_o[i] = q;
  end

  assign irq_o  = req_q;
  assign busy_o = busy_q;
endmodule

// File: rtl/irtx_checker.sv
module irtx_checker #(
  parameter int N_EMIT = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [2:0]        wr_addr,
  input logic              wr_bit0,
  input logic [N_EMIT-1:0] emit_o,
  input logic              irq_o,
  input logic              busy_o,
  input logic              mark_q,
  input logic              carrier_on,
  input logic [N_EMIT-1:0] mask_q
);
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !busy_o |=> (emit_o == '0)); // R5

  AST_SPACE_LOW: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !mark_q) |=> (emit_o == '0)); // R10

  AST_MASK_GATE: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> ((emit_o & ~$past(mask_q)) == '0)); // R9

  AST_STEADY_MARK: assert property (@(posedge clk) disable iff (rst)
    (busy_o && mark_q && !carrier_on) |=> (emit_o == $past(mask_q))); // R8

  AST_REQ_ON_START: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> irq_o); // R4

  AST_REQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !(wr_en && (wr_addr == 3'd6) && !wr_bit0)) |=> irq_o); // R4
endmodule

bind irtx_runlen irtx_checker #(.N_EMIT(N_EMIT)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_bit0(wr_data[0]),
  .emit_o(emit_o), .irq_o(irq_o), .busy_o(busy_o), .mark_q(mark_q),
  .carrier_on(carrier_on), .mask_q(mask_q)
);

// File: tb/tb_irtx_runlen.sv
`timescale 1ns/1ps
module tb_irtx_runlen;
  localparam int SC = 8;
  localparam int UC = 2;
  localparam int NE = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = 3'd0;
  logic [7:0]    wr_data = 8'd0;
  logic [NE-1:0] emit;
  logic          irq;
  logic          busy;

  irtx_runlen #(.SAMPLE_CLKS(SC), .UNIT_CLKS(UC), .N_EMIT(NE)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .emit_o(emit), .irq_o(irq), .busy_o(busy)
  );

  always #2.5 clk = ~clk;

  int nvec = 0;
  int nerr = 0;
  bit done = 1'b0;
  logic [7:0] smp [16];
  int nsmp = 0;
  int c_p = 32, c_h = 16, c_pol = 1, c_cen = 1, c_mask = 3;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int slen(int i);
    int c = int'(smp[i][6:0]);
    return ((c == 0) ? 1 : c) * SC;
  endfunction

  function automatic int total_len();
    int s = 0;
    for (int i = 0; i < nsmp; i++) s += slen(i);
    return s;
  endfunction

  // expected emitters in the n-th interval after the start edge
  function automatic logic [NE-1:0] exp_emit(int n);
    int t, pe, he;
    logic lvl;
    if (n == 0) return '0;
    t  = n - 1;
    pe = (c_p == 0) ? 1 : c_p;
    he = (c_h == 0) ? 1 : c_h;
    for (int i = 0; i < nsmp; i++) begin
      if (t < slen(i)) begin
        if (!smp[i][7]) return '0;
        if (c_cen != 0) lvl = (((t / UC) % pe) < he) ? (c_pol != 0) : (c_pol == 0);
        else            lvl = 1'b1;
        return lvl ? NE'(c_mask) : '0;
      end
      t -= slen(i);
    end
    return '0;
  endfunction

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_cfg(int p, int h, int pol, int cen, int m);
    c_p = p; c_h = h; c_pol = pol; c_cen = cen; c_mask = m;
    wr(3'd2, 8'((pol << 7) | p));
    wr(3'd3, 8'(h));
    wr(3'd4, 8'(cen));
    wr(3'd5, 8'(m));
  endtask

  task automatic run_seq(string tag);
    int tot = total_len();
    int wi = 2;
    bit rs = 1'b0;
    wr(3'd0, smp[0]);
    if (nsmp > 1) wr(3'd1, smp[1]);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd7; wr_data = 8'h00;
    @(posedge clk);
    for (int k = 0; k <= tot + 3; k++) begin
      @(negedge clk);
      wr_en = 1'b0;
      if (rs) begin
        wr_en = 1'b1; wr_addr = 3'd6; wr_data = 8'h00; rs = 1'b0;
      end else if (irq && wi < nsmp) begin
        wr_en = 1'b1; wr_addr = 3'(wi % 2); wr_data = smp[wi]; wi++; rs = 1'b1;
      end
      check({tag, " emit"}, 32'(emit), 32'(exp_emit(k)));
      check({tag, " busy (R5)"}, 32'(busy), (k < tot) ? 32'd1 : 32'd0);
    end
    @(negedge clk);
    wr_en = 1'b0;
    check({tag, " R4 flag held"}, 32'(irq), 32'd1);
    wr(3'd6, 8'h01);
    check({tag, " R4 write one ignored"}, 32'(irq), 32'd1);
    wr(3'd6, 8'h00);
    check({tag, " R4 cleared"}, 32'(irq), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset emit", 32'(emit), 32'd0);
    check("R1 reset flag", 32'(irq), 32'd0);
    check("R1 reset busy", 32'(busy), 32'd0);

    // R1: defaults without any configuration write
    nsmp = 3; smp[0] = 8'h8A; smp[1] = 8'h03; smp[2] = 8'h85;
    run_seq("R1 defaults");

    // R3: start with slot 0 empty is ignored
    wr(3'd7, 8'h00);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R3 empty start emit", 32'(emit), 32'd0);
      check("R3 empty start busy", 32'(busy), 32'd0);
      check("R3 empty start flag", 32'(irq), 32'd0);
    end

    // R6 R7: carrier period, width and polarity sweep
    for (int p = 0; p <= 5; p++)
      for (int h = 0; h <= 6; h++)
        for (int pol = 0; pol <= 1; pol++) begin
          set_cfg(p, h, pol, 1, 3);
          nsmp = 3; smp[0] = 8'h83; smp[1] = 8'h01; smp[2] = 8'h82;
          run_seq("R6 R7 carrier");
        end

    // R8: unmodulated marks
    set_cfg(4, 1, 1, 0, 3);
    nsmp = 4; smp[0] = 8'h86; smp[1] = 8'h02; smp[2] = 8'h81; smp[3] = 8'h83;
    run_seq("R8 unmodulated");

    // R9: every mask value
    for (int m = 0; m <= 3; m++) begin
      set_cfg(3, 1, 1, 1, m);
      nsmp = 2; smp[0] = 8'h84; smp[1] = 8'h02;
      run_seq("R9 mask");
    end

    // R2 R3 R10: refilled stream with zero lengths, alternating slots
    set_cfg(5, 2, 0, 1, 3);
    nsmp = 9;
    smp[0] = 8'h80; smp[1] = 8'h00; smp[2] = 8'h83; smp[3] = 8'h02; smp[4] = 8'h81;
    smp[5] = 8'h04; smp[6] = 8'h85; smp[7] = 8'h01; smp[8] = 8'h80;
    run_seq("R2 R3 R10 stream");

    // R5: single sample underrun, then restart from slot 0
    nsmp = 1; smp[0] = 8'h82;
    run_seq("R5 single");
    smp[0] = 8'h03;
    run_seq("R5 restart space");
    smp[0] = 8'h84;
    run_seq("R5 restart mark");

    // R11: maximum length
    set_cfg(3, 1, 1, 0, 1);
    nsmp = 2; smp[0] = 8'hFF; smp[1] = 8'h7F;
    run_seq("R11 max count");

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog (all requirements): actual running expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule